// File: doc/BRIEF.md
# Scaler Step Parameter Generator

This block computes the fixed-point step value that drives a video resampler, together with the values derived from it and the pre-divider code. Software, or a neighbouring control block, places a source size, a destination size and a reduction level on the inputs and pulses `start_i`. The block first pre-scales the source by the reduction level. It then forms the step as the ceiling of `effective_source * 2^FRAC_W / destination`, using a restoring divider that produces one quotient bit per clock.

When the result is ready, `done_o` rises and stays high. The step and every derived value remain stable until the next accepted start. A destination of zero does not start the divider. Instead the block reports an error with a saturated step. The pixel resampling datapath that uses these values is outside this block.

Top module: `scale_step_gen`

## Requirements
- R1: `step_o` equals ceil(eff_src * 2^21 / dst_i), 37 bits wide. Any nonzero remainder rounds the quotient up by one.
- R2: `level_i` selects the effective source, using integer (floor) shifts. Code 00 uses the full source (enlarge). Code 01 uses src_i>>1 (halve). Code 10 uses src_i>>2 (quarter). Code 11 behaves exactly as 10.
- R3: `div_code_o` reports the level of the last accepted start: 00 for enlarge, 01 for halve, 10 for quarter (levels 10 and 11).
- R4: `hstep_o` equals step_o>>2 and `hhalf_o` equals step_o>>1.
- R5: `vluma_o` equals step_o>>2 and `vluma_nxt_o` equals vluma_o + 0x514.
- R6: `vchroma_o` equals step_o>>2 when the level is enlarge and step_o>>3 otherwise. `vchroma_nxt_o` equals vchroma_o + 0x514.
- R7: Take the clock edge that accepts a start with nonzero dst_i as edge 0. From edge 0, `done_o` is low, and it rises after edge 38. It stays high, with all outputs unchanged, until the next accepted start.
- R8: A start with dst_i = 0 makes `done_o` and `err_o` high right after the accepting edge, with `step_o` all ones. The divider does not run.
- R9: A start raised while a computation is running is ignored. The result and its latency belong to the first start only.
- R10: After reset, `done_o`, `err_o` and `step_o` are zero and `div_code_o` is 00.
- R11: An accepted start with nonzero dst_i clears `err_o` at edge 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only while idle |
| src_i | input | 16 | Source size in pixels or lines |
| dst_i | input | 16 | Destination size in pixels or lines |
| level_i | input | 2 | Reduction level: 00 enlarge, 01 halve, 10/11 quarter |
| step_o | output | 37 | Rounded-up step value |
| hstep_o | output | 37 | Horizontal luma/chroma step (step>>2) |
| hhalf_o | output | 37 | Horizontal half-step companion (step>>1) |
| vluma_o | output | 37 | Vertical luma step (step>>2) |
| vluma_nxt_o | output | 37 | Vertical luma companion (+0x514) |
| vchroma_o | output | 37 | Vertical chroma step (>>2 enlarge, >>3 reduce) |
| vchroma_nxt_o | output | 37 | Vertical chroma companion (+0x514) |
| div_code_o | output | 2 | Pre-divider code of the last accepted level |
| done_o | output | 1 | Result valid, held until next accepted start |
| err_o | output | 1 | Destination was zero |

## Verification
The bench builds the block with the default parameters: 16-bit sizes and 21 fraction bits, which makes a 37-bit quotient and a 38-edge latency. With these widths the extreme ratios are within reach. A full 16-bit source over a destination of one fills every quotient bit exactly with no rounding. A source of one over the largest destination exercises rounding on a tiny remainder. Odd sources at reduced levels exercise the floor in the pre-shift. The same widths also allow direct cycle-count checks of the latency and of a start raised in the middle of a run.

// File: rtl/scale_step_pkg.sv
package scale_step_pkg;

    typedef enum logic [1:0] {
        LVL_FULL    = 2'b00,
        LVL_HALF    = 2'b01,
        LVL_QUART   = 2'b10,
        LVL_QUART_X = 2'b11
    } level_e;

    localparam int unsigned PHASE_ADD = 32'h514;

    function automatic int unsigned level_shift(level_e lv);
        case (lv)
            LVL_FULL: return 0;
            LVL_HALF: return 1;
            default:  return 2;
        endcase
    endfunction

    function automatic logic [1:0] level_code(level_e lv);
        case (lv)
            LVL_FULL: return 2'b00;
            LVL_HALF: return 2'b01;
            default:  return 2'b10;
        endcase
    endfunction

endpackage

// File: rtl/scale_step_div.sv
module scale_step_div #(
    parameter int QW = 37,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [QW-1:0] dividend_i,
    input  logic [DW-1:0] divisor_i,
    output logic [QW-1:0] quo_o,
    output logic          rem_nz_o,
    output logic          fin_o
);
    localparam int CW = $clog2(QW);

    logic [QW-1:0] work_q;
    logic [DW-1:0] rem_q;
    logic [DW-1:0] dv_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          fin_q;

    logic [DW:0]   trial;
    logic          ge;
    logic [DW-1:0] rem_nx;

    always_comb begin
        trial  = {rem_q, work_q[QW-1]};
        ge     = trial >= {1'b0, dv_q};
        rem_nx = ge ? DW'(trial - {1'b0, dv_q}) : trial[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            rem_q  <= '0;
            dv_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load_i) begin
                work_q <= dividend_i;
                rem_q  <= '0;
                dv_q   <= divisor_i;
                cnt_q  <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                work_q <= {work_q[QW-2:0], ge};
                rem_q  <= rem_nx;
                cnt_q  <= cnt_q + 1'b1;
                if (cnt_q == CW'(QW-1)) begin
                    busy_q <= 1'b0;
                    fin_q  <= 1'b1;
                end
            end
        end
    end

    assign quo_o    = work_q;
    assign rem_nz_o = |rem_q;
    assign fin_o    = fin_q;

    // R1
    rem_below_divisor_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (rem_q < dv_q));

    // R8
    no_zero_divisor_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |-> (divisor_i != '0));

    // R9
    no_reload_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !load_i);

endmodule

// File: rtl/scale_step_derive.sv
module scale_step_derive
    import scale_step_pkg::*;
#(
    parameter int QW = 37
) (
    input  logic [QW-1:0] step_i,
    input  level_e        lvl_i,
    output logic [QW-1:0] hstep_o,
    output logic [QW-1:0] hhalf_o,
    output logic [QW-1:0] vluma_o,
    output logic [QW-1:0] vluma_nxt_o,
    output logic [QW-1:0] vchroma_o,
    output logic [QW-1:0] vchroma_nxt_o
);
    localparam logic [QW-1:0] ADD_W = QW'(PHASE_ADD);

    logic [QW-1:0] quarter;

    always_comb begin
        quarter       = step_i >> 2;
        hstep_o       = quarter;
        hhalf_o       = step_i >> 1;
        vluma_o       = quarter;
        vluma_nxt_o   = quarter + ADD_W;
        vchroma_o     = (lvl_i == LVL_FULL) ? quarter : (step_i >> 3);
        vchroma_nxt_o = vchroma_o + ADD_W;
    end

endmodule

// File: rtl/scale_step_gen.sv
module scale_step_gen
    import scale_step_pkg::*;
#(
    parameter int SRC_W  = 16,
    parameter int DST_W  = 16,
    parameter int FRAC_W = 21,
    localparam int QW    = SRC_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [SRC_W-1:0] src_i,
    input  logic [DST_W-1:0] dst_i,
    input  logic [1:0]       level_i,
    output logic [QW-1:0]    step_o,
    output logic [QW-1:0]    hstep_o,
    output logic [QW-1:0]    hhalf_o,
    output logic [QW-1:0]    vluma_o,
    output logic [QW-1:0]    vluma_nxt_o,
    output logic [QW-1:0]    vchroma_o,
    output logic [QW-1:0]    vchroma_nxt_o,
    output logic [1:0]       div_code_o,
    output logic             done_o,
    output logic             err_o
);
    level_e          lvl_in;
    level_e          lvl_q;
    logic            run_q;
    logic            done_q;
    logic            err_q;
    logic [QW-1:0]   step_q;
    logic            accept;
    logic            dst_zero;
    logic [SRC_W-1:0] eff_src;
    logic [QW-1:0]   dividend;
    logic [QW-1:0]   quo;
    logic            rem_nz;
    logic            fin;

    always_comb begin
        lvl_in   = level_e'(level_i);
        accept   = start_i && !run_q;
        dst_zero = (dst_i == '0);
        eff_src  = src_i >> level_shift(lvl_in);
        dividend = {eff_src, {FRAC_W{1'b0}}};
    end

    scale_step_div #(.QW(QW), .DW(DST_W)) i_div (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept && !dst_zero),
        .dividend_i (dividend),
        .divisor_i  (dst_i),
        .quo_o      (quo),
        .rem_nz_o   (rem_nz),
        .fin_o      (fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= LVL_FULL;
            run_q  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            step_q <= '0;
        end else if (accept) begin
            lvl_q <= lvl_in;
            if (dst_zero) begin
                done_q <= 1'b1;
                err_q  <= 1'b1;
                step_q <= '1;
            end else begin
                run_q  <= 1'b1;
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end
        end else if (run_q && fin) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
            step_q <= quo + QW'(rem_nz);
        end
    end

    scale_step_derive #(.QW(QW)) i_derive (
        .step_i        (step_q),
        .lvl_i         (lvl_q),
        .hstep_o       (hstep_o),
        .hhalf_o       (hhalf_o),
        .vluma_o       (vluma_o),
        .vluma_nxt_o   (vluma_nxt_o),
        .vchroma_o     (vchroma_o),
        .vchroma_nxt_o (vchroma_nxt_o)
    );

    assign step_o     = step_q;
    assign div_code_o = level_code(lvl_q);
    assign done_o     = done_q;
    assign err_o      = err_q;

    // R8
    err_implies_done_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |-> done_q);

    // R8
    err_step_sat_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |-> (&step_q));

    // R7
    done_not_running_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !run_q);

    // R7
    start_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !run_q && dst_i != '0) |=> !done_q);

    // R9
    level_held_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q)) |-> $stable(lvl_q));

    // R7
    done_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (done_q && !start_i) |=> (done_q && $stable(step_q)));

endmodule

// File: tb/test_scale_step_gen.sv
`timescale 1ns/1ps
module test_scale_step_gen;
    localparam int QW  = 37;
    localparam int LAT = QW + 1;
    localparam int NV  = 9;

    // {src, dst, level}
    localparam logic [33:0] VEC [NV] = '{
        {16'd720,   16'd720,   2'd0},
        {16'd360,   16'd720,   2'd0},
        {16'd720,   16'd360,   2'd1},
        {16'd720,   16'd180,   2'd2},
        {16'd7,     16'd3,     2'd0},
        {16'd65535, 16'd1,     2'd0},
        {16'd1,     16'd65535, 2'd0},
        {16'd721,   16'd360,   2'd1},
        {16'd100,   16'd7,     2'd3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [15:0] src_i = '0;
    logic [15:0] dst_i = '0;
    logic [1:0]  level_i = '0;
    logic [QW-1:0] step_o, hstep_o, hhalf_o, vluma_o, vluma_nxt_o, vchroma_o, vchroma_nxt_o;
    logic [1:0] div_code_o;
    logic done_o, err_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    scale_step_gen i_scale_step_gen (
        .clk(clk), .rst(rst), .start_i(start_i), .src_i(src_i), .dst_i(dst_i),
        .level_i(level_i), .step_o(step_o), .hstep_o(hstep_o), .hhalf_o(hhalf_o),
        .vluma_o(vluma_o), .vluma_nxt_o(vluma_nxt_o), .vchroma_o(vchroma_o),
        .vchroma_nxt_o(vchroma_nxt_o), .div_code_o(div_code_o), .done_o(done_o),
        .err_o(err_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_step(input logic [15:0] s, input logic [15:0] d, input logic [1:0] l);
        longint unsigned eff, num;
        eff = (l == 2'd0) ? s : (l == 2'd1) ? (s >> 1) : (s >> 2);
        num = eff << 21;
        return (num + d - 1) / d;
    endfunction

    // Pulses start at a negedge; returns edges after the accepting edge until done is seen.
    task automatic run_op(input logic [15:0] s, input logic [15:0] d, input logic [1:0] l,
                          output int lat);
        @(negedge clk);
        src_i = s; dst_i = d; level_i = l; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 200) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic check_outputs(input string tag, input logic [63:0] e, input logic [1:0] l);
        logic [63:0] q;
        logic [63:0] c;
        q = e >> 2;
        c = (l == 2'd0) ? q : (e >> 3);
        check({tag, " R1 step"}, 64'(step_o), e);
        check({tag, " R4 hstep"}, 64'(hstep_o), q);
        check({tag, " R4 hhalf"}, 64'(hhalf_o), e >> 1);
        check({tag, " R5 vluma"}, 64'(vluma_o), q);
        check({tag, " R5 vluma_nxt"}, 64'(vluma_nxt_o), q + 64'h514);
        check({tag, " R6 vchroma"}, 64'(vchroma_o), c);
        check({tag, " R6 vchroma_nxt"}, 64'(vchroma_nxt_o), c + 64'h514);
        check({tag, " R3 div_code"}, 64'(div_code_o), (l == 2'd0) ? 64'd0 : (l == 2'd1) ? 64'd1 : 64'd2);
        check({tag, " R8 err low"}, 64'(err_o), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [63:0] e, held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 done", 64'(done_o), 64'd0);
        check("R10 err", 64'(err_o), 64'd0);
        check("R10 step", 64'(step_o), 64'd0);
        check("R10 div_code", 64'(div_code_o), 64'd0);

        // R1 R2 R3 R4 R5 R6 R7: table walk
        for (int i = 0; i < NV; i++) begin
            logic [15:0] s, d;
            logic [1:0] l;
            {s, d, l} = VEC[i];
            e = exp_step(s, d, l);
            run_op(s, d, l, lat);
            check($sformatf("R7 latency vec%0d", i), 64'(lat), 64'(LAT));
            check_outputs($sformatf("vec%0d", i), e, l);
        end

        // R7: done and outputs held while idle
        held = 64'(step_o);
        repeat (6) @(negedge clk);
        check("R7 done held", 64'(done_o), 64'd1);
        check("R7 step held", 64'(step_o), held);

        // R8: zero destination
        run_op(16'd500, 16'd0, 2'd1, lat);
        check("R8 immediate done", 64'(lat), 64'd0);
        check("R8 err", 64'(err_o), 64'd1);
        check("R8 step all ones", 64'(step_o), {27'd0, {QW{1'b1}}});
        check("R8 div_code", 64'(div_code_o), 64'd1);

        // R11: next good start clears err and done at edge 0
        @(negedge clk);
        src_i = 16'd640; dst_i = 16'd480; level_i = 2'd0; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check("R11 err cleared", 64'(err_o), 64'd0);
        check("R7 done low during run", 64'(done_o), 64'd0);
        lat = 0;
        while (!done_o && lat < 200) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        check("R11 latency", 64'(lat), 64'(LAT));
        check_outputs("R11", exp_step(16'd640, 16'd480, 2'd0), 2'd0);

        // R9: start while running ignored
        @(negedge clk);
        src_i = 16'd1000; dst_i = 16'd3; level_i = 2'd2; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        repeat (5) begin @(posedge clk); lat++; @(negedge clk); end
        src_i = 16'd9; dst_i = 16'd0; level_i = 2'd0; start_i = 1'b1;
        @(posedge clk); lat++; @(negedge clk);
        start_i = 1'b0;
        check("R9 no err from ignored start", 64'(err_o), 64'd0);
        check("R9 not done early", 64'(done_o), 64'd0);
        while (!done_o && lat < 200) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        check("R9 latency of first start", 64'(lat), 64'(LAT));
        check_outputs("R9", exp_step(16'd1000, 16'd3, 2'd2), 2'd2);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule